// File: doc/BRIEF.md
# Timer Output Compare Waveform Unit

This block combines a 16-bit timer counter with one output compare channel and the logic that drives a pin from it. A host writes the counter, the compare value, the counter's upper limit and a two-bit compare-output mode, and it can pulse a force strobe. Each timer tick the counter either counts up and wraps at its upper limit, or, in dual-slope operation, climbs to the limit and then falls back to zero. When the count equals the compare value on a tick, the unit emits a one-cycle hit pulse. The mode then decides whether an internal waveform flip-flop toggles, clears, sets or stays as it is.

A counter write blocks every compare event for the next timer tick. This applies to the compare hit, the wrap at the upper limit and the turn at zero. The host can therefore reposition the counter without triggering a spurious event. Mode writes take effect from the following clock and are not tied to the compare value. Whenever the mode is nonzero, the waveform flip-flop replaces the general port data bit on the pin. The port direction bit alone still decides whether the pin drives.

Top module: `tmr_ocu_top`

## Requirements
- R1: After reset the count is 0, the compare value is 0, the upper limit is 0xFFFF, the mode is 00 and the waveform flip-flop is 0. With mode 00, `pin_out` follows `port_data`.
- R2: With `dual_slope`=0, each cycle with `tick`=1 advances the count by one. A count equal to the upper limit returns to 0 on the next tick. With `tick`=0 the count holds.
- R3: With `dual_slope`=1 and an upper limit of at least 1, the count rises to the upper limit and then decreases one per tick down to 0. It then rises again.
- R4: `cmp_hit` is 1 exactly in cycles where `tick`=1, the count equals the compare value and no block is pending.
- R5: A counter write sets a block that suppresses every compare event on the next tick. The block holds however many idle cycles pass before that tick. A value written equal to the compare value therefore produces no hit on that tick.
- R6: Writing the count equal to the upper limit suppresses the wrap. The count continues upward through 0xFFFF and then rolls over to 0.
- R7: In dual-slope operation while counting down, writing 0 suppresses the turn at zero. The count continues to 0xFFFF and keeps counting down.
- R8: On a compare event, mode 01 toggles the waveform flip-flop, mode 10 clears it and mode 11 sets it. Mode 00 leaves it unchanged.
- R9: `force_stb`=1 applies the same mode action as a hit in that cycle. It does not change the count and does not raise `cmp_hit`. A force and a hit in the same cycle act only once.
- R10: A mode write is used from the next clock edge. The waveform flip-flop keeps its value across mode changes.
- R11: When the mode is nonzero, `pin_out` equals the waveform flip-flop. When the mode is 00, `pin_out` equals `port_data`. `pin_oe` always equals `port_dir`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timer clock enable, one count step per high cycle |
| dual_slope | input | 1 | 0: count up and wrap; 1: count up then down |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | 16 | Counter write value |
| cmp_wr | input | 1 | Compare value write strobe |
| cmp_wdata | input | 16 | Compare value |
| top_wr | input | 1 | Upper limit write strobe |
| top_wdata | input | 16 | Upper limit value |
| mode_wr | input | 1 | Mode write strobe |
| mode_wdata | input | 2 | Mode: 00 off, 01 toggle, 10 clear, 11 set |
| force_stb | input | 1 | Force a compare action on the waveform flip-flop |
| port_data | input | 1 | General port data bit |
| port_dir | input | 1 | Port direction bit (1 = drive) |
| count | output | 16 | Current count |
| cmp_hit | output | 1 | One-cycle compare hit pulse |
| pin_out | output | 1 | Pin output value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The assertions check several properties on every cycle. A counter write never produces a hit on the next cycle. A hit only occurs on a tick. The wrap and the turn at zero move the count as required. The waveform flip-flop changes only on a hit or a force, and each mode drives it to the required level. A forced action without a tick leaves the count untouched. The bench's scenarios are needed for the behaviours that stretch over many cycles. These include blocking that survives idle cycles and passing the limit up to the 0xFFFF rollover. They also include the wrap below zero when counting down, and a held waveform value reappearing on the pin after the mode returns from 00.

// File: rtl/tmr_ocu_pkg.sv
// Shared types for the timer output compare unit.
// Assumes nothing beyond a two-bit mode field.
package tmr_ocu_pkg;
    typedef enum logic [1:0] {
        OC_OFF    = 2'b00,
        OC_TOGGLE = 2'b01,
        OC_CLEAR  = 2'b10,
        OC_SET    = 2'b11
    } oc_mode_e;
endpackage

// File: rtl/tmr_ocu_counter.sv
// Up or dual-slope counter with a programmable upper limit.
// Assumes the upper limit is at least 1 in dual-slope operation.
// Limit and zero events are ignored while the block flag from the match unit is set.
module tmr_ocu_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dual_slope,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         top_wr,
    input  logic [W-1:0] top_data,
    input  logic         blk,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] ALL1 = '1;
    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = W'(1);

    logic [W-1:0] cnt_q, cnt_d, top_q;
    logic         down_q, down_d;
    logic         at_top, at_bot;

    assign at_top = (cnt_q == top_q);
    assign at_bot = (cnt_q == ZERO);

    // Next count and direction for one timer tick or host write
    always_comb begin
        cnt_d  = cnt_q;
        down_d = dual_slope ? down_q : 1'b0;
        if (wr_en) begin
            cnt_d = wr_data;
        end else if (tick) begin
            if (!dual_slope) begin
                cnt_d = (at_top && !blk) ? ZERO : cnt_q + ONE;
            end else if (!down_q) begin
                if (at_top && !blk) begin
                    down_d = 1'b1;
                    cnt_d  = cnt_q - ONE;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end else begin
                if (at_bot && !blk) begin
                    down_d = 1'b0;
                    cnt_d  = cnt_q + ONE;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end
        end
    end

    // Counter, direction and upper limit registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= ZERO;
            down_q <= 1'b0;
            top_q  <= ALL1;
        end else begin
            cnt_q  <= cnt_d;
            down_q <= down_d;
            if (top_wr) top_q <= top_data;
        end
    end

    assign cnt = cnt_q;

    // R2
    wrap_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope && !wr_en && !top_wr && !blk && cnt_q == top_q) |=> (cnt_q == ZERO));
    // R6
    blocked_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !dual_slope && !wr_en && blk && cnt_q == top_q) |=> (cnt_q == $past(cnt_q) + ONE));
    // R3
    turn_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && down_q && !wr_en && !blk && cnt_q == ZERO) |=> (cnt_q == ONE));
    // R7
    blocked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && dual_slope && down_q && !wr_en && blk && cnt_q == ZERO) |=> (cnt_q == ALL1));
endmodule

// File: rtl/tmr_ocu_match.sv
// Compare register, write block flag and compare hit detection.
// The block flag is set by a counter write and cleared by the next tick.
module tmr_ocu_match #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_data,
    output logic         blk,
    output logic         hit
);
    logic [W-1:0] cmp_q;
    logic         blk_q;

    // Compare register, written directly with no buffering
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '0;
        else if (cmp_wr) cmp_q <= cmp_data;
    end

    // Block flag: armed by a counter write, consumed by the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)      blk_q <= 1'b0;
        else if (cnt_wr) blk_q <= 1'b1;
        else if (tick)   blk_q <= 1'b0;
    end

    assign blk = blk_q;
    assign hit = tick && !blk_q && (cnt == cmp_q);

    // R5
    write_blocks_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> !hit);
    // R4
    hit_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> tick);
endmodule

// File: rtl/tmr_ocu_wave.sv
// Waveform flip-flop, mode register and pin override multiplexer.
// A hit or a force strobe applies the current mode's action once.
module tmr_ocu_wave
    import tmr_ocu_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit,
    input  logic       force_stb,
    input  logic       mode_wr,
    input  logic [1:0] mode_data,
    input  logic       port_data,
    input  logic       port_dir,
    output logic       pin_out,
    output logic       pin_oe
);
    oc_mode_e mode_q;
    logic     ocf_q, ocf_d, evt;

    assign evt = hit || force_stb;

    // Action taken on the waveform flip-flop for a compare event
    always_comb begin
        ocf_d = ocf_q;
        if (evt) begin
            unique case (mode_q)
                OC_TOGGLE: ocf_d = ~ocf_q;
                OC_CLEAR:  ocf_d = 1'b0;
                OC_SET:    ocf_d = 1'b1;
                default:   ocf_d = ocf_q;
            endcase
        end
    end

    // Mode and waveform registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= OC_OFF;
            ocf_q  <= 1'b0;
        end else begin
            ocf_q <= ocf_d;
            if (mode_wr) mode_q <= oc_mode_e'(mode_data);
        end
    end

    // Pin value source selection; direction stays with the port
    assign pin_out = (mode_q != OC_OFF) ? ocf_q : port_data;
    assign pin_oe  = port_dir;

    // R8
    set_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == OC_SET) |=> ocf_q);
    // R8
    clear_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == OC_CLEAR) |=> !ocf_q);
    // R8
    toggle_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && mode_q == OC_TOGGLE) |=> (ocf_q != $past(ocf_q)));
    // R10
    hold_without_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !evt |=> $stable(ocf_q));
endmodule

// File: rtl/tmr_ocu_top.sv
// Timer output compare waveform unit: counter, match detection,
// waveform flip-flop and pin override. Assumes tick is a one-cycle enable.
module tmr_ocu_top
    import tmr_ocu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         dual_slope,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic         cmp_wr,
    input  logic [W-1:0] cmp_wdata,
    input  logic         top_wr,
    input  logic [W-1:0] top_wdata,
    input  logic         mode_wr,
    input  logic [1:0]   mode_wdata,
    input  logic         force_stb,
    input  logic         port_data,
    input  logic         port_dir,
    output logic [W-1:0] count,
    output logic         cmp_hit,
    output logic         pin_out,
    output logic         pin_oe
);
    logic [W-1:0] cnt;
    logic         blk, hit;

    tmr_ocu_counter #(.W(W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dual_slope(dual_slope),
        .wr_en(cnt_wr), .wr_data(cnt_wdata), .top_wr(top_wr),
        .top_data(top_wdata), .blk(blk), .cnt(cnt)
    );

    tmr_ocu_match #(.W(W)) u_match (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_wr(cnt_wr), .cnt(cnt),
        .cmp_wr(cmp_wr), .cmp_data(cmp_wdata), .blk(blk), .hit(hit)
    );

    tmr_ocu_wave u_wave (
        .clk(clk), .rst_n(rst_n), .hit(hit), .force_stb(force_stb),
        .mode_wr(mode_wr), .mode_data(mode_wdata), .port_data(port_data),
        .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    assign count   = cnt;
    assign cmp_hit = hit;

    // R9
    force_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (force_stb && !tick && !cnt_wr) |=> $stable(count));
endmodule

// File: tb/tb_tmr_ocu_top.sv
`timescale 1ns/1ps
module tb_tmr_ocu_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0, dual_slope = 1'b0;
    logic        cnt_wr = 1'b0, cmp_wr = 1'b0, top_wr = 1'b0, mode_wr = 1'b0;
    logic [15:0] cnt_wdata = '0, cmp_wdata = '0, top_wdata = '0;
    logic [1:0]  mode_wdata = '0;
    logic        force_stb = 1'b0, port_data = 1'b0, port_dir = 1'b0;
    logic [15:0] count;
    logic        cmp_hit, pin_out, pin_oe;

    int n_checks = 0, n_fail = 0;
    bit done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_cnt, m_cmp, m_top, m_mode, m_ocf, m_blk, m_down;

    always #5 clk = ~clk;

    tmr_ocu_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .dual_slope(dual_slope),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cmp_wr(cmp_wr),
        .cmp_wdata(cmp_wdata), .top_wr(top_wr), .top_wdata(top_wdata),
        .mode_wr(mode_wr), .mode_wdata(mode_wdata), .force_stb(force_stb),
        .port_data(port_data), .port_dir(port_dir), .count(count),
        .cmp_hit(cmp_hit), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    task automatic check(string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, what, act, exp);
        end
    endtask

    function automatic int exp_pin();
        return (m_mode != 0) ? m_ocf : int'(port_data);
    endfunction

    task automatic model_reset();
        m_cnt = 0; m_cmp = 0; m_top = 16'hFFFF; m_mode = 0;
        m_ocf = 0; m_blk = 0; m_down = 0;
    endtask

    // one clock: check the hit, advance the model, check registered outputs
    task automatic step();
        int hit, ev, n_cnt, n_down;
        #1;
        hit = (tick && m_blk == 0 && m_cnt == m_cmp) ? 1 : 0;
        check("cmp_hit", int'(cmp_hit), hit);
        ev = hit | int'(force_stb);
        n_cnt = m_cnt;
        n_down = dual_slope ? m_down : 0;
        if (cnt_wr) n_cnt = int'(cnt_wdata);
        else if (tick) begin
            if (!dual_slope)
                n_cnt = (m_cnt == m_top && m_blk == 0) ? 0 : (m_cnt + 1) % 65536;
            else if (m_down == 0) begin
                if (m_cnt == m_top && m_blk == 0) begin n_down = 1; n_cnt = (m_cnt + 65535) % 65536; end
                else n_cnt = (m_cnt + 1) % 65536;
            end else begin
                if (m_cnt == 0 && m_blk == 0) begin n_down = 0; n_cnt = 1; end
                else n_cnt = (m_cnt + 65535) % 65536;
            end
        end
        if (ev) begin
            if (m_mode == 1) m_ocf = 1 - m_ocf;
            else if (m_mode == 2) m_ocf = 0;
            else if (m_mode == 3) m_ocf = 1;
        end
        if (cnt_wr) m_blk = 1; else if (tick) m_blk = 0;
        if (mode_wr) m_mode = int'(mode_wdata);
        if (cmp_wr) m_cmp = int'(cmp_wdata);
        if (top_wr) m_top = int'(top_wdata);
        m_cnt = n_cnt; m_down = n_down;
        @(posedge clk); #1;
        check("count", int'(count), m_cnt);
        check("pin_out", int'(pin_out), exp_pin());
        check("pin_oe", int'(pin_oe), int'(port_dir));
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr_cnt(int v);
        cnt_wr = 1; cnt_wdata = 16'(v); step(); cnt_wr = 0;
    endtask
    task automatic wr_cmp(int v);
        cmp_wr = 1; cmp_wdata = 16'(v); step(); cmp_wr = 0;
    endtask
    task automatic wr_top(int v);
        top_wr = 1; top_wdata = 16'(v); step(); top_wr = 0;
    endtask
    task automatic wr_mode(int v);
        mode_wr = 1; mode_wdata = 2'(v); step(); mode_wr = 0;
    endtask
    task automatic pulse_force();
        force_stb = 1; step(); force_stb = 0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        port_data = 1; port_dir = 1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        cur_req = "R1";
        check("count", int'(count), 0);
        check("pin_out", int'(pin_out), 1);
        check("pin_oe", int'(pin_oe), 1);
        rst_n = 1;
        step();

        // R2: up counting with wrap at a small limit, hold when tick low
        cur_req = "R2";
        wr_top(5);
        wr_cnt(0);
        tick = 1; run(14);
        tick = 0; run(3);

        // R4 and R8: hits at compare value with each mode action
        cur_req = "R4";
        wr_cmp(3);
        cur_req = "R8";
        wr_mode(1);
        tick = 1; run(13);
        wr_mode(3); run(7);
        wr_mode(2); run(7);
        wr_mode(0); run(7);

        // R5: write equal to compare blocks the hit, block survives idle cycles
        cur_req = "R5";
        wr_mode(1);
        tick = 1;
        wr_cnt(3); run(8);
        tick = 0; wr_cnt(3); run(4);
        tick = 1; run(8);

        // R6: write equal to limit passes the limit up to rollover
        cur_req = "R6";
        wr_top(10);
        wr_cnt(10); run(4);
        wr_cnt(16'hFFFE); run(4);

        // R3: dual-slope counting
        cur_req = "R3";
        dual_slope = 1;
        wr_top(4);
        wr_cnt(0); run(14);

        // R7: writing zero while counting down wraps below zero
        cur_req = "R7";
        wr_cnt(3); run(2);
        wr_cnt(0); run(3);
        wr_cnt(2); run(10);
        dual_slope = 0;

        // R9: force changes only the waveform, not count or hit
        cur_req = "R9";
        tick = 0;
        wr_mode(1);
        pulse_force(); pulse_force(); pulse_force();
        run(2);
        wr_cmp(int'(count)); tick = 1; force_stb = 1; step(); force_stb = 0;
        tick = 0; run(2);

        // R10: waveform holds across a mode change to off and back
        cur_req = "R10";
        wr_mode(3); pulse_force();
        wr_mode(0);
        port_data = 0; run(2);
        wr_mode(1); run(2);
        wr_mode(2); run(1);

        // R11: pin override and direction follow the port bits
        cur_req = "R11";
        port_dir = 0; port_data = 1; run(2);
        wr_mode(0); port_data = 0; run(1); port_data = 1; run(1);
        port_dir = 1; run(2);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule